// File: doc/BRIEF.md
# Multi-Core Global Timer with Banked Comparators

This block keeps one 64-bit up-counter that every processor core in a cluster shares. A shared enable bit starts and stops the counter, and a shared divider field sets its rate. Each core also has its own comparator slice. A slice holds a 64-bit compare value, a sticky event flag, an interrupt line and an optional step value that moves the compare value forward after each hit. Together these give every core a periodic or one-shot tick, all taken from the same time base.

Software reaches the block through a plain 32-bit register port. An access carries a byte offset inside a 32-byte window and a core index. The core index picks which slice's registers the access sees and changes. The counter and the shared control fields look the same from every core. The control register mixes the two kinds of bits: shared bits and the accessing core's private bits appear in one word. Reads are combinational and return data in the same cycle as the request. Writes take effect at the next rising clock edge.

Top module: `mgt_global_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the shared enable and divider, and every core's control bits, flag, compare value and step value. It also drives every interrupt output low.
- R2: Offset 0x00 holds counter bits 31:0 and offset 0x04 holds bits 63:32. Every core sees the same counter value. While the timer is stopped, a write to either half loads that half, and otherwise the counter holds its value.
- R3: While the shared enable (control bit 0) is set, writes to either counter half are ignored.
- R4: While running, the counter advances by exactly one every D+1 clock cycles, where D is control bits 15:8. The first step lands D+1 edges after the edge that writes the enable.
- R5: Control (offset 0x08) is built from two kinds of bits. Bit 0 (enable) and bits 15:8 (divider) are shared. Bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (step enable) are private to each core. A read returns the shared bits merged with the accessing core's private bits. A write updates the shared bits and only that core's private bits.
- R6: A core's comparator value lives at 0x10 (bits 31:0) and 0x14 (bits 63:32). The core's flag is set only when the timer is enabled, the core's compare enable is set, and the counter is greater than or equal to the compare value. The flag is set at the first edge at which that holds.
- R7: The flag is bit 0 of offset 0x0C and stays set until cleared. Writing 1 to bit 0 clears it and writing 0 has no effect. A hit in the same cycle as a clear leaves the flag set.
- R8: A core's interrupt output is high exactly while that core's flag and interrupt enable are both set.
- R9: The step value lives at offset 0x18. If step enable is set and the step is nonzero, the compare value grows by the step on each cycle that the hit condition holds. This stops at the first value above the counter. A zero step leaves the compare value unchanged.
- R10: Offset 0x1C and any offset not a multiple of 4 read as zero, and writes there are ignored. A core index of NCORES or more reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Byte offset within the 32-byte window |
| req_core | input | ID_W | Index of the accessing core |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as the read request; zero otherwise |
| irq_o | output | NCORES | Per-core interrupt lines |

## Verification
Register traffic is first applied with the timer stopped. Writes from one core index and reads from another separate the shared fields from the private ones and reveal any bleed between slices. The out-of-range index and the unused offset are also tried at this stage. With the timer running, a divider of 3 shows the exact step cadence and the rejection of counter writes, and a divider of 0 shows that a hit is detected on the exact cycle the counter equals the compare value. A large divider keeps the counter still while a compare value far below it catches up in several steps, ending exactly one step above the counter. In the same run a zero step shows the compare value held in place.

// File: rtl/mgt_pkg.sv
package mgt_pkg;

    localparam int BUS_W   = 32;
    localparam int CNT_W   = 64;
    localparam int PRESC_W = 8;
    localparam int ADDR_W  = 5;

    // Control word bit positions
    localparam int CB_TEN     = 0;
    localparam int CB_CMP     = 1;
    localparam int CB_IRQ     = 2;
    localparam int CB_AUTO    = 3;
    localparam int CB_PRE_LSB = 8;

    // Word index inside the register window
    typedef enum logic [2:0] {
        RI_CNT_LO = 3'd0,
        RI_CNT_HI = 3'd1,
        RI_CTRL   = 3'd2,
        RI_STAT   = 3'd3,
        RI_CMP_LO = 3'd4,
        RI_CMP_HI = 3'd5,
        RI_INCR   = 3'd6,
        RI_NONE   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic auto_en;
        logic irq_en;
        logic cmp_en;
    } bank_ctl_t;

    typedef struct packed {
        logic               ten;
        logic [PRESC_W-1:0] presc;
    } shared_ctl_t;

    function automatic bank_ctl_t unpack_bank(input logic [BUS_W-1:0] w);
        bank_ctl_t b;
        b.cmp_en  = w[CB_CMP];
        b.irq_en  = w[CB_IRQ];
        b.auto_en = w[CB_AUTO];
        return b;
    endfunction

    function automatic shared_ctl_t unpack_shared(input logic [BUS_W-1:0] w);
        shared_ctl_t s;
        s.ten   = w[CB_TEN];
        s.presc = w[CB_PRE_LSB +: PRESC_W];
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctl(input shared_ctl_t s, input bank_ctl_t b);
        logic [BUS_W-1:0] w;
        w                         = '0;
        w[CB_TEN]                 = s.ten;
        w[CB_PRE_LSB +: PRESC_W]  = s.presc;
        w[CB_CMP]                 = b.cmp_en;
        w[CB_IRQ]                 = b.irq_en;
        w[CB_AUTO]                = b.auto_en;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BUS_W-1:0] d);
        logic [CNT_W-1:0] r;
        r = v;
        if (hi) r[CNT_W-1:BUS_W] = d;
        else    r[BUS_W-1:0]     = d;
        return r;
    endfunction

endpackage

// File: rtl/mgt_counter.sv
module mgt_counter
    import mgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  shared_ctl_t        sh,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BUS_W-1:0]   wdata,
    output logic [CNT_W-1:0]   cnt
);

    logic [PRESC_W-1:0] div_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (sh.ten) begin
            // running: loads are dropped, divider paces the increment
            if (div_q >= sh.presc) begin
                div_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end else begin
            div_q <= '0;
            if (wr_lo)      cnt_q <= put_half(cnt_q, 1'b0, wdata);
            else if (wr_hi) cnt_q <= put_half(cnt_q, 1'b1, wdata);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/mgt_cmp_bank.sv
module mgt_cmp_bank
    import mgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             timer_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ctl_we,
    input  logic             stat_we,
    input  logic             cmp_lo_we,
    input  logic             cmp_hi_we,
    input  logic             inc_we,
    input  logic [BUS_W-1:0] wdata,
    output bank_ctl_t        ctl,
    output logic [CNT_W-1:0] cmp,
    output logic [BUS_W-1:0] incr,
    output logic             flag,
    output logic             irq
);

    localparam int PAD_W = CNT_W - BUS_W;

    bank_ctl_t        ctl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cmp_d;
    logic [BUS_W-1:0] incr_q;
    logic             flag_q;
    logic             hit;
    logic             step;

    assign hit  = timer_en && ctl_q.cmp_en && (cnt >= cmp_q);
    assign step = hit && ctl_q.auto_en && (incr_q != '0);

    always_comb begin
        cmp_d = cmp_q;
        if (step)      cmp_d = cmp_q + {{PAD_W{1'b0}}, incr_q};
        // software load has priority over the hardware step
        if (cmp_lo_we) cmp_d = put_half(cmp_q, 1'b0, wdata);
        if (cmp_hi_we) cmp_d = put_half(cmp_q, 1'b1, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cmp_q  <= '0;
            incr_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctl_we) ctl_q  <= unpack_bank(wdata);
            if (inc_we) incr_q <= wdata;
            cmp_q  <= cmp_d;
            flag_q <= (flag_q && !(stat_we && wdata[0])) || hit;
        end
    end

    assign ctl  = ctl_q;
    assign cmp  = cmp_q;
    assign incr = incr_q;
    assign flag = flag_q;
    assign irq  = flag_q && ctl_q.irq_en;

endmodule

// File: rtl/mgt_regif.sv
module mgt_regif
    import mgt_pkg::*;
#(
    parameter int NCORES = 3,
    localparam int ID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [ID_W-1:0]                req_core,
    // state to read back
    input  logic [CNT_W-1:0]               cnt,
    input  shared_ctl_t                    sh,
    input  bank_ctl_t   [NCORES-1:0]       bctl,
    input  logic        [NCORES-1:0]       flag,
    input  logic        [NCORES-1:0][CNT_W-1:0] cmp,
    input  logic        [NCORES-1:0][BUS_W-1:0] incr,
    // write strobes
    output logic                           wr_cnt_lo,
    output logic                           wr_cnt_hi,
    output logic                           wr_ctl,
    output logic        [NCORES-1:0]       ctl_we,
    output logic        [NCORES-1:0]       stat_we,
    output logic        [NCORES-1:0]       cmp_lo_we,
    output logic        [NCORES-1:0]       cmp_hi_we,
    output logic        [NCORES-1:0]       inc_we,
    output logic [BUS_W-1:0]               rd_data
);

    localparam logic [ID_W:0] NC_L = (ID_W + 1)'(NCORES);

    reg_idx_e          ridx;
    logic              core_ok;
    logic              aligned;
    logic              acc;
    logic              wr;
    logic [NCORES-1:0] csel;

    assign aligned = (req_addr[1:0] == 2'b00);
    assign ridx    = aligned ? reg_idx_e'(req_addr[ADDR_W-1:2]) : RI_NONE;
    assign core_ok = ({1'b0, req_core} < NC_L);
    assign acc     = req_valid && core_ok;
    assign wr      = acc && req_write;

    assign wr_cnt_lo = wr && (ridx == RI_CNT_LO);
    assign wr_cnt_hi = wr && (ridx == RI_CNT_HI);
    assign wr_ctl    = wr && (ridx == RI_CTRL);

    for (genvar i = 0; i < NCORES; i++) begin : g_sel
        assign csel[i]      = (req_core == ID_W'(i));
        assign ctl_we[i]    = wr_ctl && csel[i];
        assign stat_we[i]   = wr && csel[i] && (ridx == RI_STAT);
        assign cmp_lo_we[i] = wr && csel[i] && (ridx == RI_CMP_LO);
        assign cmp_hi_we[i] = wr && csel[i] && (ridx == RI_CMP_HI);
        assign inc_we[i]    = wr && csel[i] && (ridx == RI_INCR);
    end

    bank_ctl_t        s_ctl;
    logic             s_flag;
    logic [CNT_W-1:0] s_cmp;
    logic [BUS_W-1:0] s_inc;

    always_comb begin
        s_ctl  = '0;
        s_flag = 1'b0;
        s_cmp  = '0;
        s_inc  = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (csel[i]) begin
                s_ctl  = bctl[i];
                s_flag = flag[i];
                s_cmp  = cmp[i];
                s_inc  = incr[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc && !req_write) begin
            case (ridx)
                RI_CNT_LO: rd_data = cnt[BUS_W-1:0];
                RI_CNT_HI: rd_data = cnt[CNT_W-1:BUS_W];
                RI_CTRL:   rd_data = pack_ctl(sh, s_ctl);
                RI_STAT:   rd_data = {{(BUS_W-1){1'b0}}, s_flag};
                RI_CMP_LO: rd_data = s_cmp[BUS_W-1:0];
                RI_CMP_HI: rd_data = s_cmp[CNT_W-1:BUS_W];
                RI_INCR:   rd_data = s_inc;
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/mgt_global_timer.sv
module mgt_global_timer
    import mgt_pkg::*;
#(
    parameter int NCORES = 3,
    localparam int ID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_addr,
    input  logic [ID_W-1:0]   req_core,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic [NCORES-1:0] irq_o
);

    shared_ctl_t sh_q;
    logic [CNT_W-1:0] cnt;

    logic wr_cnt_lo;
    logic wr_cnt_hi;
    logic wr_ctl;
    logic [NCORES-1:0] ctl_we;
    logic [NCORES-1:0] stat_we;
    logic [NCORES-1:0] cmp_lo_we;
    logic [NCORES-1:0] cmp_hi_we;
    logic [NCORES-1:0] inc_we;

    bank_ctl_t [NCORES-1:0]             bctl;
    logic      [NCORES-1:0]             flag;
    logic      [NCORES-1:0][CNT_W-1:0]  cmp;
    logic      [NCORES-1:0][BUS_W-1:0]  incr;

    always_ff @(posedge clk) begin
        if (rst)         sh_q <= '0;
        else if (wr_ctl) sh_q <= unpack_shared(req_wdata);
    end

    mgt_regif #(.NCORES(NCORES)) u_regif (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_core  (req_core),
        .cnt       (cnt),
        .sh        (sh_q),
        .bctl      (bctl),
        .flag      (flag),
        .cmp       (cmp),
        .incr      (incr),
        .wr_cnt_lo (wr_cnt_lo),
        .wr_cnt_hi (wr_cnt_hi),
        .wr_ctl    (wr_ctl),
        .ctl_we    (ctl_we),
        .stat_we   (stat_we),
        .cmp_lo_we (cmp_lo_we),
        .cmp_hi_we (cmp_hi_we),
        .inc_we    (inc_we),
        .rd_data   (rd_data)
    );

    mgt_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .sh    (sh_q),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (req_wdata),
        .cnt   (cnt)
    );

    for (genvar i = 0; i < NCORES; i++) begin : g_bank
        mgt_cmp_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .timer_en  (sh_q.ten),
            .cnt       (cnt),
            .ctl_we    (ctl_we[i]),
            .stat_we   (stat_we[i]),
            .cmp_lo_we (cmp_lo_we[i]),
            .cmp_hi_we (cmp_hi_we[i]),
            .inc_we    (inc_we[i]),
            .wdata     (req_wdata),
            .ctl       (bctl[i]),
            .cmp       (cmp[i]),
            .incr      (incr[i]),
            .flag      (flag[i]),
            .irq       (irq_o[i])
        );
    end

endmodule

// File: rtl/mgt_global_timer_chk.sv
module mgt_global_timer_chk #(
    parameter int NCORES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              timer_en,
    input logic [63:0]       cnt,
    input logic              cnt_wr,
    input logic [NCORES-1:0] flag,
    input logic [NCORES-1:0] stat_we,
    input logic              wbit0,
    input logic [NCORES-1:0] irq
);

    // R1: the cycle after reset everything is cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt == 64'd0 && flag == '0 && irq == '0));

    // R4: a running counter moves by at most one per cycle
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        timer_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1));

    // R2: a stopped counter without a load keeps its value
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (!timer_en && !cnt_wr) |=> $stable(cnt));

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        // R7: flag stays set unless a one is written to it
        p_sticky_flag_r7: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !(stat_we[i] && wbit0)) |=> flag[i]);

        // R8: an interrupt never appears without its flag
        p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> flag[i]);

        // R6: no new event while the timer is stopped
        p_no_event_stopped_r6: assert property (@(posedge clk) disable iff (rst)
            (!timer_en && !flag[i]) |=> !flag[i]);
    end

endmodule

bind mgt_global_timer mgt_global_timer_chk #(.NCORES(NCORES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .timer_en (sh_q.ten),
    .cnt      (cnt),
    .cnt_wr   (wr_cnt_lo | wr_cnt_hi),
    .flag     (flag),
    .stat_we  (stat_we),
    .wbit0    (req_wdata[0]),
    .irq      (irq_o)
);

// File: tb/mgt_global_timer_tb.sv
module mgt_global_timer_tb_top;

    localparam int NC   = 3;
    localparam int ID_W = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [4:0]      req_addr  = '0;
    logic [ID_W-1:0] req_core  = '0;
    logic [31:0]     req_wdata = '0;
    logic [31:0]     rd_data;
    logic [NC-1:0]   irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    mgt_global_timer #(.NCORES(NC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_core  (req_core),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  core;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    // data is write data for writes and expected value for reads
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 5'h00, 32'h0000_0000, 4'd1},  // R1 counter low
        '{1'b1, 2'd1, 5'h08, 32'h0000_0000, 4'd1},  // R1 control
        '{1'b1, 2'd2, 5'h14, 32'h0000_0000, 4'd1},  // R1 compare high
        '{1'b1, 2'd1, 5'h0C, 32'h0000_0000, 4'd1},  // R1 flag
        '{1'b0, 2'd0, 5'h00, 32'h89AB_CDEF, 4'd2},  // R2 load low
        '{1'b0, 2'd0, 5'h04, 32'h0123_4567, 4'd2},  // R2 load high
        '{1'b1, 2'd1, 5'h00, 32'h89AB_CDEF, 4'd2},  // R2 shared view
        '{1'b1, 2'd2, 5'h04, 32'h0123_4567, 4'd2},  // R2 shared view
        '{1'b0, 2'd1, 5'h08, 32'h0000_0006, 4'd5},  // R5 core1 private
        '{1'b1, 2'd1, 5'h08, 32'h0000_0006, 4'd5},  // R5
        '{1'b1, 2'd0, 5'h08, 32'h0000_0000, 4'd5},  // R5 no bleed
        '{1'b0, 2'd0, 5'h08, 32'h0000_AB08, 4'd5},  // R5 core0 + divider
        '{1'b1, 2'd1, 5'h08, 32'h0000_AB06, 4'd5},  // R5 merged view
        '{1'b1, 2'd0, 5'h08, 32'h0000_AB08, 4'd5},  // R5 merged view
        '{1'b0, 2'd2, 5'h10, 32'h1111_2222, 4'd6},  // R6 compare low
        '{1'b1, 2'd2, 5'h10, 32'h1111_2222, 4'd6},  // R6
        '{1'b1, 2'd0, 5'h10, 32'h0000_0000, 4'd6},  // R6 private
        '{1'b0, 2'd1, 5'h18, 32'h0000_0040, 4'd9},  // R9 step
        '{1'b1, 2'd1, 5'h18, 32'h0000_0040, 4'd9},  // R9
        '{1'b1, 2'd2, 5'h18, 32'h0000_0000, 4'd9},  // R9 private
        '{1'b0, 2'd0, 5'h1C, 32'hFFFF_FFFF, 4'd10}, // R10 unused offset
        '{1'b1, 2'd0, 5'h1C, 32'h0000_0000, 4'd10}, // R10
        '{1'b0, 2'd3, 5'h08, 32'hFFFF_FFFF, 4'd10}, // R10 bad core
        '{1'b1, 2'd0, 5'h08, 32'h0000_AB08, 4'd10}, // R10 unchanged
        '{1'b1, 2'd3, 5'h08, 32'h0000_0000, 4'd10}, // R10 bad core reads 0
        '{1'b1, 2'd1, 5'h0C, 32'h0000_0000, 4'd6},  // R6 stopped: no hit
        '{1'b0, 2'd0, 5'h14, 32'hDEAD_BEEF, 4'd6},  // R6 compare high
        '{1'b1, 2'd0, 5'h14, 32'hDEAD_BEEF, 4'd6}   // R6
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] core, input logic [4:0] addr, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_core  = core; req_addr  = addr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] core, input logic [4:0] addr, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0;
        req_core  = core; req_addr  = addr;
        #1;
        d = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        do_reset();
        check({61'd0, irq_o}, 64'd0, "R1 irq low after reset");

        // table walk
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_rd) begin
                rd(VECS[k].core, VECS[k].addr, v);
                check({32'd0, v}, {32'd0, VECS[k].data},
                      $sformatf("R%0d vector %0d", VECS[k].rq, k));
            end else begin
                wr(VECS[k].core, VECS[k].addr, VECS[k].data);
            end
        end

        // R1: reset after activity
        do_reset();
        rd(2'd0, 5'h04, v); check({32'd0, v}, 64'd0, "R1 counter high cleared");
        rd(2'd0, 5'h08, v); check({32'd0, v}, 64'd0, "R1 control cleared");
        rd(2'd2, 5'h10, v); check({32'd0, v}, 64'd0, "R1 compare cleared");
        rd(2'd1, 5'h18, v); check({32'd0, v}, 64'd0, "R1 step cleared");

        // R4 / R3 / R2: divider 3, run, rejected load, stop, hold
        wr(2'd0, 5'h08, 32'h0000_0301);
        repeat (10) @(negedge clk);
        rd(2'd0, 5'h00, v); check({32'd0, v}, 64'd2, "R4 count after 10 edges");
        wr(2'd0, 5'h00, 32'h0000_FFFF);
        rd(2'd1, 5'h00, v); check({32'd0, v}, 64'd3, "R3 load ignored while running");
        wr(2'd0, 5'h08, 32'h0000_0300);
        rd(2'd0, 5'h00, v); check({32'd0, v}, 64'd3, "R4 stopped value");
        repeat (6) @(negedge clk);
        rd(2'd0, 5'h00, v); check({32'd0, v}, 64'd3, "R2 hold while stopped");

        // R6 / R8 / R7: divider 0, compare 20 on core1
        do_reset();
        wr(2'd1, 5'h10, 32'd20);
        wr(2'd1, 5'h08, 32'h0000_0007);
        repeat (20) @(negedge clk);
        check({61'd0, irq_o}, 64'd0, "R6 no hit below compare");
        @(negedge clk);
        check({61'd0, irq_o}, 64'b010, "R6 hit at equal, R8 irq on core1 only");
        rd(2'd0, 5'h0C, v); check({32'd0, v}, 64'd0, "R6 core0 disabled no flag");
        wr(2'd1, 5'h08, 32'h0000_0003);
        check({61'd0, irq_o}, 64'd0, "R8 irq masked");
        rd(2'd1, 5'h0C, v); check({32'd0, v}, 64'd1, "R8 flag kept while masked");
        wr(2'd1, 5'h0C, 32'h0000_0000);
        rd(2'd1, 5'h0C, v); check({32'd0, v}, 64'd1, "R7 write 0 no effect");
        wr(2'd1, 5'h0C, 32'h0000_0001);
        rd(2'd1, 5'h0C, v); check({32'd0, v}, 64'd1, "R7 hit beats clear");
        wr(2'd1, 5'h08, 32'h0000_0001);
        wr(2'd1, 5'h0C, 32'h0000_0001);
        rd(2'd1, 5'h0C, v); check({32'd0, v}, 64'd0, "R7 clear by writing 1");

        // R9: catch-up with divider 255, zero step on core1
        do_reset();
        wr(2'd0, 5'h00, 32'd1000);
        wr(2'd0, 5'h10, 32'd100);
        wr(2'd0, 5'h18, 32'd300);
        wr(2'd1, 5'h10, 32'd100);
        wr(2'd1, 5'h08, 32'h0000_FF0A);
        wr(2'd0, 5'h08, 32'h0000_FF0B);
        repeat (10) @(negedge clk);
        rd(2'd0, 5'h10, v); check({32'd0, v}, 64'd1300, "R9 compare passes counter");
        rd(2'd0, 5'h14, v); check({32'd0, v}, 64'd0, "R9 compare high unchanged");
        rd(2'd0, 5'h0C, v); check({32'd0, v}, 64'd1, "R9 flag set by hit");
        rd(2'd1, 5'h10, v); check({32'd0, v}, 64'd100, "R9 zero step holds compare");
        rd(2'd1, 5'h0C, v); check({32'd0, v}, 64'd1, "R9 zero step core still flags");
        rd(2'd2, 5'h00, v); check({32'd0, v}, 64'd1000, "R4 counter still before first tick");

        finish_run();
    end

endmodule